// File: doc/BRIEF.md
# Memory Type Range Lookup

This block turns a physical address into a cacheability type. It holds three kinds of range register. The first is a single 64-bit register that splits the legacy window 0xA0000–0xBFFFF into eight 16 KiB slices, each with its own 8-bit type field. The second is a set of variable base/mask pairs that can describe regions of any power-of-two size anywhere in the physical space. The third is a default register that supplies the type when no range claims the address.

A requester presents an address with a valid strobe. The resolution logic is combinational, and one clock later the block returns the type together with a hit flag. The hit flag is low only when the default register supplied the answer. Software programs the registers through a simple indexed write/read port. A write takes effect at the clock edge, so a lookup issued in the same cycle still sees the old contents. The type codes are uncached = 0x00, write-through = 0x04 and write-back = 0x06. Any other byte value is stored and returned unchanged.

The block has no state machine. It has one register process for the configuration, one for the result stage, and purely combinational matching and priority logic between them.

Top module: `mtr_lookup`

## Requirements
- R1: An address whose bits 35:17 equal 5 (range 0xA0000–0xBFFFF) resolves to byte k of the fixed register, bits 8k+7:8k, where k = address bits 16:14. The hit flag is 1.
- R2: Inside the fixed window the fixed field is returned even when a valid variable pair also matches the address.
- R3: Variable pair i matches when (address[35:12] & mask[35:12]) equals (base[35:12] & mask[35:12]) and mask bit 11 is set. It returns base bits 7:0 with hit = 1.
- R4: A pair whose mask bit 11 is clear never matches, whatever its base and mask hold.
- R5: When several valid pairs match outside the fixed window, the result is uncached (0x00) if any matching pair carries 0x00. Otherwise the result is the type of the lowest-numbered matching pair.
- R6: When neither the fixed window nor any valid pair matches, the result is bits 7:0 of the default register and the hit flag is 0.
- R7: Register index 0 is the fixed register, 1 is the default register, 2+2i is base of pair i and 3+2i is mask of pair i. A register is written at the rising edge where reg_we is 1.
- R8: reg_rdata combinationally returns the register selected by reg_addr, with bits the register does not keep reading as 0. Base keeps bits 35:12 and 7:0, mask keeps bits 35:12 and 11, the default register keeps bits 7:0, and an unmapped index reads 0.
- R9: res_valid is 1 exactly in the cycle after a cycle with lk_valid = 1, and it carries the result computed from the register contents of that earlier cycle. A write in the same cycle as a lookup does not affect that lookup. With lk_valid = 0, res_type and res_hit hold.
- R10: While rst_n is 0, res_valid, res_type and res_hit are 0 and every range register clears to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index for write and read |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data (combinational) |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 36 | Physical address to resolve |
| res_valid | output | 1 | Result strobe, one cycle after lk_valid |
| res_type | output | 8 | Resolved memory type |
| res_hit | output | 1 | 1 when a fixed or variable range supplied the type |

## Verification
Two events can fall in the same cycle: a register write and a lookup that depends on the register being written. The bench provokes this by rewriting slice 0 of the fixed register in the very cycle it requests address 0xA0000. It expects the pre-write type in that result and the new type in the following lookup. A second collision lies inside the resolver. Overlapping fixed, uncached-variable and write-back-variable ranges are programmed so that one address is claimed by several sources at once, and each result is judged against the priority order of R2 and R5.

// File: rtl/mtr_pkg.sv
package mtr_pkg;

    // Memory type codes used by the resolver and the bench.
    localparam logic [7:0] MT_UC = 8'h00;
    localparam logic [7:0] MT_WT = 8'h04;
    localparam logic [7:0] MT_WB = 8'h06;

    // Fixed register and default register indices.
    localparam int REG_FIX  = 0;
    localparam int REG_DFLT = 1;
    localparam int REG_VAR0 = 2;

    // Legacy window: 0xA0000 .. 0xBFFFF, eight 16 KiB slices.
    localparam int          FIX_SLICE_LSB = 14;
    localparam int          FIX_TAG_LSB   = 17;
    localparam logic [35:0] FIX_LO        = 36'h0_000A_0000;

    // Variable register layout.
    localparam int PG_LSB    = 12;
    localparam int VLD_BIT   = 11;

endpackage

// File: rtl/mtr_regs.sv
module mtr_regs
    import mtr_pkg::*;
#(
    parameter  int PA_W    = 36,
    parameter  int NUM_VAR = 4,
    parameter  int RA_W    = 4,
    localparam int PG_W    = PA_W - PG_LSB
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [RA_W-1:0]               addr,
    input  logic [63:0]                   wdata,
    output logic [63:0]                   rdata,
    output logic [63:0]                   fix_q,
    output logic [7:0]                    dflt_q,
    output logic [NUM_VAR-1:0][PG_W-1:0]  base_pg,
    output logic [NUM_VAR-1:0][7:0]       base_kind,
    output logic [NUM_VAR-1:0][PG_W-1:0]  mask_pg,
    output logic [NUM_VAR-1:0]            mask_vld
);

    // Fixed and default registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fix_q  <= '0;
            dflt_q <= '0;
        end else if (we) begin
            if (addr == RA_W'(REG_FIX))  fix_q  <= wdata;
            if (addr == RA_W'(REG_DFLT)) dflt_q <= wdata[7:0];
        end
    end

    // One base/mask pair per variable range.
    for (genvar i = 0; i < NUM_VAR; i++) begin : g_pair
        localparam int BASE_IDX = REG_VAR0 + 2 * i;
        localparam int MASK_IDX = REG_VAR0 + 2 * i + 1;

        logic [PG_W-1:0] b_pg_q;
        logic [7:0]      b_kind_q;
        logic [PG_W-1:0] m_pg_q;
        logic            m_vld_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                b_pg_q   <= '0;
                b_kind_q <= '0;
                m_pg_q   <= '0;
                m_vld_q  <= 1'b0;
            end else if (we) begin
                if (addr == RA_W'(BASE_IDX)) begin
                    b_pg_q   <= wdata[PA_W-1:PG_LSB];
                    b_kind_q <= wdata[7:0];
                end
                if (addr == RA_W'(MASK_IDX)) begin
                    m_pg_q  <= wdata[PA_W-1:PG_LSB];
                    m_vld_q <= wdata[VLD_BIT];
                end
            end
        end

        assign base_pg[i]   = b_pg_q;
        assign base_kind[i] = b_kind_q;
        assign mask_pg[i]   = m_pg_q;
        assign mask_vld[i]  = m_vld_q;
    end

    // Read mux: unkept bits return zero.
    always_comb begin
        rdata = '0;
        if (addr == RA_W'(REG_FIX)) begin
            rdata = fix_q;
        end else if (addr == RA_W'(REG_DFLT)) begin
            rdata = {56'b0, dflt_q};
        end
        for (int i = 0; i < NUM_VAR; i++) begin
            if (addr == RA_W'(REG_VAR0 + 2 * i)) begin
                rdata = (64'(base_pg[i]) << PG_LSB) | 64'(base_kind[i]);
            end
            if (addr == RA_W'(REG_VAR0 + 2 * i + 1)) begin
                rdata = (64'(mask_pg[i]) << PG_LSB) | (64'(mask_vld[i]) << VLD_BIT);
            end
        end
    end

endmodule

// File: rtl/mtr_var_match.sv
module mtr_var_match #(
    parameter int PG_W = 24
) (
    input  logic [PG_W-1:0] addr_pg,
    input  logic [PG_W-1:0] base_pg,
    input  logic [PG_W-1:0] mask_pg,
    input  logic            vld,
    input  logic [7:0]      base_kind,
    output logic            hit,
    output logic [7:0]      kind
);

    logic [PG_W-1:0] addr_m;
    logic [PG_W-1:0] base_m;

    assign addr_m = addr_pg & mask_pg;
    assign base_m = base_pg & mask_pg;
    assign hit    = vld && (addr_m == base_m);
    assign kind   = base_kind;

endmodule

// File: rtl/mtr_resolve.sv
module mtr_resolve
    import mtr_pkg::*;
#(
    parameter int NUM_VAR = 4
) (
    input  logic                     in_fix,
    input  logic [7:0]               fix_kind,
    input  logic [NUM_VAR-1:0]       var_hit,
    input  logic [NUM_VAR-1:0][7:0]  var_kind,
    input  logic [7:0]               dflt_kind,
    output logic [7:0]               kind,
    output logic                     hit
);

    logic       uc_seen;
    logic       any_seen;
    logic [7:0] first_kind;

    // Scan the pairs: note any uncached match and the lowest-indexed match.
    always_comb begin
        uc_seen    = 1'b0;
        any_seen   = 1'b0;
        first_kind = dflt_kind;
        for (int i = NUM_VAR - 1; i >= 0; i--) begin
            if (var_hit[i]) begin
                any_seen   = 1'b1;
                first_kind = var_kind[i];
                if (var_kind[i] == MT_UC) uc_seen = 1'b1;
            end
        end
    end

    // Priority: fixed window, uncached overlap, lowest pair, default.
    always_comb begin
        if (in_fix) begin
            kind = fix_kind;
            hit  = 1'b1;
        end else if (uc_seen) begin
            kind = MT_UC;
            hit  = 1'b1;
        end else if (any_seen) begin
            kind = first_kind;
            hit  = 1'b1;
        end else begin
            kind = dflt_kind;
            hit  = 1'b0;
        end
    end

endmodule

// File: rtl/mtr_lookup.sv
module mtr_lookup
    import mtr_pkg::*;
#(
    parameter  int NUM_VAR = 4,
    parameter  int PA_W    = 36,
    localparam int RA_W    = $clog2(REG_VAR0 + 2 * NUM_VAR),
    localparam int PG_W    = PA_W - PG_LSB
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_we,
    input  logic [RA_W-1:0] reg_addr,
    input  logic [63:0]     reg_wdata,
    output logic [63:0]     reg_rdata,
    input  logic            lk_valid,
    input  logic [PA_W-1:0] lk_addr,
    output logic            res_valid,
    output logic [7:0]      res_type,
    output logic            res_hit
);

    localparam logic [PA_W-1:0] FIX_LO_W = PA_W'(FIX_LO);

    logic [63:0]                  fix_q;
    logic [7:0]                   dflt_q;
    logic [NUM_VAR-1:0][PG_W-1:0] base_pg;
    logic [NUM_VAR-1:0][7:0]      base_kind;
    logic [NUM_VAR-1:0][PG_W-1:0] mask_pg;
    logic [NUM_VAR-1:0]           mask_vld;

    logic [NUM_VAR-1:0]           var_hit;
    logic [NUM_VAR-1:0][7:0]      var_kind;

    logic                         in_fix;
    logic [2:0]                   fix_slice;
    logic [7:0]                   fix_kind;
    logic [7:0]                   nxt_kind;
    logic                         nxt_hit;
    logic                         lk_addr_unused;

    mtr_regs #(
        .PA_W    (PA_W),
        .NUM_VAR (NUM_VAR),
        .RA_W    (RA_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (reg_we),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .fix_q     (fix_q),
        .dflt_q    (dflt_q),
        .base_pg   (base_pg),
        .base_kind (base_kind),
        .mask_pg   (mask_pg),
        .mask_vld  (mask_vld)
    );

    for (genvar i = 0; i < NUM_VAR; i++) begin : g_match
        mtr_var_match #(
            .PG_W (PG_W)
        ) u_match (
            .addr_pg   (lk_addr[PA_W-1:PG_LSB]),
            .base_pg   (base_pg[i]),
            .mask_pg   (mask_pg[i]),
            .vld       (mask_vld[i]),
            .base_kind (base_kind[i]),
            .hit       (var_hit[i]),
            .kind      (var_kind[i])
        );
    end

    // Fixed window decode.
    assign in_fix    = (lk_addr[PA_W-1:FIX_TAG_LSB] == FIX_LO_W[PA_W-1:FIX_TAG_LSB]);
    assign fix_slice = lk_addr[FIX_TAG_LSB-1:FIX_SLICE_LSB];
    assign fix_kind  = fix_q[{fix_slice, 3'b000} +: 8];

    assign lk_addr_unused = ^lk_addr[PG_LSB-1:0];

    mtr_resolve #(
        .NUM_VAR (NUM_VAR)
    ) u_resolve (
        .in_fix    (in_fix),
        .fix_kind  (fix_kind),
        .var_hit   (var_hit),
        .var_kind  (var_kind),
        .dflt_kind (dflt_q),
        .kind      (nxt_kind),
        .hit       (nxt_hit)
    );

    // Result stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_type  <= '0;
            res_hit   <= 1'b0;
        end else begin
            res_valid <= lk_valid;
            if (lk_valid) begin
                res_type <= nxt_kind;
                res_hit  <= nxt_hit;
            end
        end
    end

endmodule

// File: rtl/mtr_lookup_chk.sv
module mtr_lookup_chk
    import mtr_pkg::*;
#(
    parameter int NUM_VAR = 4,
    parameter int PA_W    = 36
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    lk_valid,
    input logic [PA_W-1:0]         lk_addr,
    input logic                    res_valid,
    input logic [7:0]              res_type,
    input logic                    res_hit,
    input logic [63:0]             fix_q,
    input logic [7:0]              dflt_q,
    input logic [NUM_VAR-1:0]      var_hit,
    input logic [NUM_VAR-1:0][7:0] var_kind
);

    localparam logic [PA_W-1:0] FIX_LO_W = PA_W'(FIX_LO);

    logic               chk_in_fix;
    logic [NUM_VAR-1:0] chk_uc;
    logic               chk_unused;

    assign chk_in_fix = (lk_addr[PA_W-1:FIX_TAG_LSB] == FIX_LO_W[PA_W-1:FIX_TAG_LSB]);
    assign chk_unused = ^lk_addr[FIX_SLICE_LSB-1:0];

    always_comb begin
        for (int i = 0; i < NUM_VAR; i++) chk_uc[i] = var_hit[i] && (var_kind[i] == MT_UC);
    end

    // R10
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (!res_valid && !res_hit && res_type == 8'h00));

    // R9
    req_to_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid);

    // R9
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !res_valid);

    // R9
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> ($stable(res_type) && $stable(res_hit)));

    // R6
    default_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !chk_in_fix && var_hit == '0) |=> (!res_hit && res_type == $past(dflt_q)));

    // R1
    fixed_slice_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && chk_in_fix) |=>
            (res_hit && res_type == 8'($past(fix_q) >> {$past(lk_addr[16:14]), 3'b000})));

    // R5
    uc_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !chk_in_fix && chk_uc != '0) |=> (res_hit && res_type == MT_UC));

endmodule

bind mtr_lookup mtr_lookup_chk #(
    .NUM_VAR (NUM_VAR),
    .PA_W    (PA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_valid  (lk_valid),
    .lk_addr   (lk_addr),
    .res_valid (res_valid),
    .res_type  (res_type),
    .res_hit   (res_hit),
    .fix_q     (fix_q),
    .dflt_q    (dflt_q),
    .var_hit   (var_hit),
    .var_kind  (var_kind)
);

// File: tb/tb_mtr_lookup.sv
module tb_mtr_lookup;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        lk_valid = 1'b0;
    logic [35:0] lk_addr = '0;
    logic        res_valid;
    logic [7:0]  res_type;
    logic        res_hit;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    mtr_lookup dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .lk_valid  (lk_valid),
        .lk_addr   (lk_addr),
        .res_valid (res_valid),
        .res_type  (res_type),
        .res_hit   (res_hit)
    );

    // Slices 0..7 of the fixed window: 06 00 06 04 00 06 04 06
    localparam logic [63:0] FIX_A = 64'h06_04_06_00_04_06_00_06;
    localparam logic [63:0] FIX_B = 64'h06_04_06_00_04_06_00_04;

    // {address, expected type, expected hit}
    localparam int NV = 17;
    localparam logic [47:0] VEC [NV] = '{
        {36'h0_000A_0000, 8'h06, 4'h1},   // R1 slice 0
        {36'h0_000A_4000, 8'h00, 4'h1},   // R1 slice 1
        {36'h0_000A_BFFF, 8'h06, 4'h1},   // R1 slice 2 top byte
        {36'h0_000A_C000, 8'h04, 4'h1},   // R1 slice 3
        {36'h0_000B_0000, 8'h00, 4'h1},   // R1 slice 4
        {36'h0_000B_4000, 8'h06, 4'h1},   // R1 slice 5
        {36'h0_000B_8000, 8'h04, 4'h1},   // R1 slice 6
        {36'h0_000B_FFFF, 8'h06, 4'h1},   // R1 slice 7, R2 over pair 2
        {36'h0_0009_FFFF, 8'h04, 4'h1},   // R3 pair 2 below window
        {36'h0_000C_0000, 8'h04, 4'h1},   // R3 pair 2 above window
        {36'h0_0010_0000, 8'h06, 4'h1},   // R3 pair 0
        {36'h0_0017_FFFF, 8'h06, 4'h1},   // R3 pair 0 top of lower half
        {36'h0_0018_0000, 8'h00, 4'h1},   // R5 pair 1 UC over pair 0 WB
        {36'h0_001F_FFFF, 8'h00, 4'h1},   // R5 overlap top
        {36'h0_0020_0000, 8'h06, 4'h0},   // R6 miss
        {36'h0_0040_0000, 8'h06, 4'h0},   // R4 pair 3 invalid
        {36'hF_FFFF_F000, 8'h06, 4'h0}    // R6 top of space
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] idx, input logic [63:0] data);
        @(negedge clk);
        reg_we    = 1'b1;
        reg_addr  = idx;
        reg_wdata = data;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic rd(input logic [3:0] idx, input logic [63:0] exp, input string req);
        @(negedge clk);
        reg_addr = idx;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic look(input logic [35:0] a, input logic [7:0] et, input logic eh, input string req);
        @(negedge clk);
        lk_valid = 1'b1;
        lk_addr  = a;
        @(negedge clk);
        lk_valid = 1'b0;
        chk({req, " valid"}, 64'(res_valid), 64'(1'b1));
        chk({req, " type"},  64'(res_type),  64'(et));
        chk({req, " hit"},   64'(res_hit),   64'(eh));
    endtask

    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R10: reset state
        repeat (5) @(negedge clk);
        chk("R10 res_valid", 64'(res_valid), 0);
        chk("R10 res_type",  64'(res_type),  0);
        chk("R10 res_hit",   64'(res_hit),   0);
        rst_n = 1'b1;
        rd(4'd0, 64'h0, "R10 fixed cleared");
        rd(4'd3, 64'h0, "R10 mask0 cleared");
        look(36'h0_0020_0000, 8'h00, 1'b0, "R10 default after reset");

        // R7: program the map
        wr(4'd0, FIX_A);
        wr(4'd1, 64'hFFFF_FFFF_FFFF_FF06);         // default WB, junk above
        wr(4'd2, 64'hF000_0000_0010_0F06);         // base0 0x100000 WB, junk
        wr(4'd3, 64'h0000_000F_FFF0_0800);         // mask0 1 MiB valid
        wr(4'd4, 64'h0000_0000_0018_0000);         // base1 0x180000 UC
        wr(4'd5, 64'h0000_000F_FFF8_0800);         // mask1 512 KiB valid
        wr(4'd6, 64'h0000_0000_0000_0004);         // base2 0 WT
        wr(4'd7, 64'h0000_000F_FFF0_0800);         // mask2 1 MiB valid
        wr(4'd8, 64'h0000_0000_0040_0004);         // base3 0x400000 WT
        wr(4'd9, 64'h0000_000F_FFC0_0000);         // mask3 invalid

        // R8: readback with unkept bits cleared
        rd(4'd0, FIX_A, "R8 fixed readback");
        rd(4'd1, 64'h06, "R8 default keeps low byte");
        rd(4'd2, 64'h0000_0000_0010_0006, "R8 base drops unkept bits");
        rd(4'd5, 64'h0000_000F_FFF8_0800, "R8 mask readback");
        rd(4'd12, 64'h0, "R8 unmapped index");

        // Table walk
        for (int i = 0; i < NV; i++) begin
            string tag;
            if (VEC[i][3:0] == 4'h0)              tag = "R6/R4 miss";
            else if (VEC[i][47:29] == 19'd5)      tag = "R1/R2 fixed";
            else                                  tag = "R3/R5 variable";
            look(VEC[i][47:12], VEC[i][11:4], VEC[i][0], tag);
        end

        // R9: outputs hold and res_valid drops while idle
        repeat (3) @(negedge clk);
        chk("R9 idle res_valid", 64'(res_valid), 0);
        chk("R9 idle type hold", 64'(res_type),  64'h06);
        chk("R9 idle hit hold",  64'(res_hit),   0);

        // R9: write and lookup in the same cycle
        @(negedge clk);
        reg_we    = 1'b1;
        reg_addr  = 4'd0;
        reg_wdata = FIX_B;
        lk_valid  = 1'b1;
        lk_addr   = 36'h0_000A_0000;
        @(negedge clk);
        reg_we   = 1'b0;
        lk_valid = 1'b0;
        chk("R9 same-cycle sees old", 64'(res_type), 64'h06);
        look(36'h0_000A_0000, 8'h04, 1'b1, "R9 next lookup sees new");

        // R5: non-UC overlap, lowest pair wins
        wr(4'd8, 64'h0000_0000_0010_0004);         // base3 0x100000 WT
        wr(4'd9, 64'h0000_000F_FFF0_0800);         // mask3 valid
        look(36'h0_0010_0000, 8'h06, 1'b1, "R5 lowest pair wins");
        look(36'h0_0018_0000, 8'h00, 1'b1, "R5 UC still wins");

        // R4: clear valid bit of pair 2
        wr(4'd7, 64'h0000_000F_FFF0_0000);
        look(36'h0_000C_0000, 8'h06, 1'b0, "R4 invalidated pair");
        // R2: fixed window unaffected
        look(36'h0_000A_4000, 8'h00, 1'b1, "R2 fixed window");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule